// File: doc/BRIEF.md
# RAS Error Node Signaling Controller

This block sits beside one error-reporting node of a reliability subsystem. It keeps the node's 64-bit control word behind a small memory-mapped write/read port and turns classified error events into signals: a fault-handling interrupt, an error-recovery interrupt, a critical-error interrupt and an in-band error-response flag. Each event arrives with a class (corrected, deferred, uncorrected, critical) and a side (read or write). A separate counter-overflow strobe can also stand in for corrected-error events.

Elaboration parameters set how each control is built. A control can be absent, where its bit reads as zero and ignores writes. It can be shared, where one bit serves reads and writes. It can be split, where the low bit serves reads and a second bit serves writes. Signaling depends only on the event class, its side and the enables. It takes nothing from the error record, so an event whose syndrome the record discards (because the record already holds a higher-priority error) is signaled like any other event.

Top module: `ras_node_sigctl`

## Requirements
- R1: After reset the control word reads as all zeros and all four outputs are low.
- R2: The control word responds only at byte address 0x008 + 64*NODE_IDX (0x048 by default). A read at any other address returns zero, and a write at any other address leaves the word unchanged.
- R3: Writes store only the implemented bits. Bits 31:16 and the bits of absent controls always read zero. Bit 1 and bits 63:32 hold whatever value was written. With the default parameters the writable mask is 0xFFFFFFFF0000FD7F.
- R4: While bit 0 (reporting enable) is clear, no output is asserted for any event.
- R5: A shared control uses only its low bit, whatever the side. A split control uses its low bit for read events and its high bit for write events. The pairs are: uncorrected recovery 2/5, fault 3/6, in-band 4/7, corrected fault 8/9, deferred recovery 10/11 and deferred fault 14/15.
- R6: A deferred event (class 2'b01) raises the fault interrupt exactly when, for its side, the deferred-fault bit XOR the fault bit is 1.
- R7: A deferred event raises the recovery interrupt when its side's deferred-recovery bit is set. An uncorrected event (class 2'b10) raises it when its side's uncorrected-recovery bit is set.
- R8: A critical event (class 2'b11) raises only the critical interrupt when bit 13 is set. When bit 13 is clear it raises no critical interrupt and is handled exactly as an uncorrected event.
- R9: When bit 12 is set, a corrected event (class 2'b00) is a corrected-error event and the overflow strobe is ignored. When bit 12 is clear, only the overflow strobe counts. A corrected-error event raises the fault interrupt when its side's corrected-fault bit is set.
- R10: The in-band error flag rises only for uncorrected events, and for critical events, when the in-band bit is set. It never rises for corrected or deferred events.
- R11: An uncorrected event raises the fault interrupt when its side's fault bit is set.
- R12: Each output is registered. It goes high in the cycle after the event is sampled and stays high for that one cycle only, unless another event follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from bus_addr |
| evt_valid | input | 1 | A classified error event is present |
| evt_class | input | 2 | 00 corrected, 01 deferred, 10 uncorrected, 11 critical |
| evt_is_write | input | 1 | Event came from a write (1) or a read (0) |
| cnt_ovf | input | 1 | Corrected-error counter overflow strobe |
| fhi_irq | output | 1 | Fault-handling interrupt pulse |
| eri_irq | output | 1 | Error-recovery interrupt pulse |
| cri_irq | output | 1 | Critical-error interrupt pulse |
| inband_err | output | 1 | In-band error response flag pulse |

## Verification
The hardest cases to reach from the ports are those where the outcome hinges on the XOR of two enables, or on which side of a split control applies. One control word can make a deferred read fire and a deferred write stay quiet. The stimulus therefore rewrites the control word before each group of events with a chosen combination: both bits of a pair, one bit only, read-side only and write-side only. It then sends the same event class from both sides. The corrected-event source switch is covered the same way: a corrected event and a bare overflow strobe are each sent under both settings of bit 12.

// File: rtl/ras_sig_pkg.sv
package ras_sig_pkg;

    typedef enum logic [1:0] {
        CLS_CORR   = 2'b00,
        CLS_DEFER  = 2'b01,
        CLS_UNCORR = 2'b10,
        CLS_CRIT   = 2'b11
    } err_class_e;

    // feature build codes
    localparam logic [1:0] FEAT_NONE  = 2'b00;
    localparam logic [1:0] FEAT_BOTH  = 2'b10;
    localparam logic [1:0] FEAT_SPLIT = 2'b11;

    // control word bit positions (neighbouring software decodes these)
    localparam int B_RPT    = 0;
    localparam int B_UREC   = 2;
    localparam int B_FLT    = 3;
    localparam int B_IBR    = 4;
    localparam int B_UREC_W = 5;
    localparam int B_FLT_W  = 6;
    localparam int B_IBR_W  = 7;
    localparam int B_CEF    = 8;
    localparam int B_CEF_W  = 9;
    localparam int B_DREC   = 10;
    localparam int B_DREC_W = 11;
    localparam int B_CSRC   = 12;
    localparam int B_CRIT   = 13;
    localparam int B_DFLT   = 14;
    localparam int B_DFLT_W = 15;

    typedef struct packed {
        logic fault;
        logic recov;
        logic crit;
        logic inband;
    } sig_set_t;

    // resolve one enable for the side of the current event
    function automatic logic pick_en(logic [1:0] feat, logic lo, logic hi, logic is_wr);
        logic en;
        unique case (feat)
            FEAT_BOTH:  en = lo;
            FEAT_SPLIT: en = is_wr ? hi : lo;
            default:    en = 1'b0;
        endcase
        return en;
    endfunction

    function automatic logic [63:0] pair_bits(logic [1:0] feat, int lo, int hi);
        logic [63:0] m;
        m = '0;
        if (feat == FEAT_BOTH || feat == FEAT_SPLIT) m[lo] = 1'b1;
        if (feat == FEAT_SPLIT) m[hi] = 1'b1;
        return m;
    endfunction

    // writable-bit mask built from the feature parameters
    function automatic logic [63:0] ctl_mask(
        logic [1:0] f_rpt, logic [1:0] f_urec, logic [1:0] f_flt,
        logic [1:0] f_ibr, logic [1:0] f_cef, logic [1:0] f_drec,
        logic [1:0] f_dflt, logic [1:0] f_crit, logic has_csrc);
        logic [63:0] m;
        m = 64'hFFFF_FFFF_0000_0002;
        if (f_rpt == FEAT_BOTH)  m[B_RPT]  = 1'b1;
        if (f_crit == FEAT_BOTH) m[B_CRIT] = 1'b1;
        if (has_csrc)            m[B_CSRC] = 1'b1;
        m = m | pair_bits(f_urec, B_UREC, B_UREC_W)
              | pair_bits(f_flt,  B_FLT,  B_FLT_W)
              | pair_bits(f_ibr,  B_IBR,  B_IBR_W)
              | pair_bits(f_cef,  B_CEF,  B_CEF_W)
              | pair_bits(f_drec, B_DREC, B_DREC_W)
              | pair_bits(f_dflt, B_DFLT, B_DFLT_W);
        return m;
    endfunction

endpackage

// File: rtl/ras_ctl_reg.sv
module ras_ctl_reg #(
    parameter int          ADDR_W  = 16,
    parameter int          REG_OFF = 8,
    parameter logic [63:0] WMASK   = 64'hFFFF_FFFF_0000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic [15:2]       ctl_en,
    output logic              rpt_bit
);

    logic [63:0] ctl_q;
    logic        hit;

    assign hit = (addr == ADDR_W'(REG_OFF));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && hit) begin
            ctl_q <= wdata & WMASK;
        end
    end

    assign rdata   = hit ? ctl_q : '0;
    assign ctl_en  = ctl_q[15:2];
    assign rpt_bit = ctl_q[0];

endmodule

// File: rtl/ras_evt_gate.sv
module ras_evt_gate
    import ras_sig_pkg::*;
#(
    parameter logic [1:0] FEAT_UREC = FEAT_SPLIT,
    parameter logic [1:0] FEAT_FLT  = FEAT_SPLIT,
    parameter logic [1:0] FEAT_IBR  = FEAT_BOTH,
    parameter logic [1:0] FEAT_CEF  = FEAT_BOTH,
    parameter logic [1:0] FEAT_DREC = FEAT_SPLIT,
    parameter logic [1:0] FEAT_DFLT = FEAT_SPLIT,
    parameter logic [1:0] FEAT_CRIT = FEAT_BOTH,
    parameter bit         HAS_CSRC  = 1'b1
) (
    input  logic [15:2] ctl_en,
    input  logic        evt_valid,
    input  err_class_e  evt_class,
    input  logic        evt_is_write,
    input  logic        cnt_ovf,
    output sig_set_t    sig
);

    logic ce_evt;
    logic urec, flt, ibr, cef, drec, dflt, crit_on;
    logic is_def, is_unc;

    // corrected-event source depends on whether the selector bit is built
    generate
        if (HAS_CSRC) begin : g_csrc
            assign ce_evt = ctl_en[B_CSRC] ? (evt_valid && evt_class == CLS_CORR) : cnt_ovf;
        end else begin : g_cnt_only
            assign ce_evt = cnt_ovf;
        end
    endgenerate

    always_comb begin
        urec    = pick_en(FEAT_UREC, ctl_en[B_UREC], ctl_en[B_UREC_W], evt_is_write);
        flt     = pick_en(FEAT_FLT,  ctl_en[B_FLT],  ctl_en[B_FLT_W],  evt_is_write);
        ibr     = pick_en(FEAT_IBR,  ctl_en[B_IBR],  ctl_en[B_IBR_W],  evt_is_write);
        cef     = pick_en(FEAT_CEF,  ctl_en[B_CEF],  ctl_en[B_CEF_W],  evt_is_write);
        drec    = pick_en(FEAT_DREC, ctl_en[B_DREC], ctl_en[B_DREC_W], evt_is_write);
        dflt    = pick_en(FEAT_DFLT, ctl_en[B_DFLT], ctl_en[B_DFLT_W], evt_is_write);
        crit_on = (FEAT_CRIT == FEAT_BOTH) && ctl_en[B_CRIT];

        is_def = evt_valid && (evt_class == CLS_DEFER);
        // a critical error without its own interrupt falls back to uncorrected handling
        is_unc = evt_valid && ((evt_class == CLS_UNCORR) ||
                               ((evt_class == CLS_CRIT) && !crit_on));

        sig.fault  = (ce_evt && cef) || (is_def && (dflt ^ flt)) || (is_unc && flt);
        sig.recov  = (is_def && drec) || (is_unc && urec);
        sig.crit   = evt_valid && (evt_class == CLS_CRIT) && crit_on;
        sig.inband = evt_valid && ((evt_class == CLS_UNCORR) || (evt_class == CLS_CRIT)) && ibr;
    end

endmodule

// File: rtl/ras_irq_out.sv
module ras_irq_out
    import ras_sig_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rpt_on,
    input  sig_set_t sig,
    output logic     fhi_irq,
    output logic     eri_irq,
    output logic     cri_irq,
    output logic     inband_err
);

    sig_set_t out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (rpt_on) begin
            out_q <= sig;
        end else begin
            out_q <= '0;
        end
    end

    assign fhi_irq    = out_q.fault;
    assign eri_irq    = out_q.recov;
    assign cri_irq    = out_q.crit;
    assign inband_err = out_q.inband;

endmodule

// File: rtl/ras_node_sigctl.sv
module ras_node_sigctl
    import ras_sig_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         NODE_IDX  = 1,
    parameter logic [1:0] FEAT_RPT  = FEAT_BOTH,
    parameter logic [1:0] FEAT_UREC = FEAT_SPLIT,
    parameter logic [1:0] FEAT_FLT  = FEAT_SPLIT,
    parameter logic [1:0] FEAT_IBR  = FEAT_BOTH,
    parameter logic [1:0] FEAT_CEF  = FEAT_BOTH,
    parameter logic [1:0] FEAT_DREC = FEAT_SPLIT,
    parameter logic [1:0] FEAT_DFLT = FEAT_SPLIT,
    parameter logic [1:0] FEAT_CRIT = FEAT_BOTH,
    parameter bit         HAS_CSRC  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic              evt_valid,
    input  logic [1:0]        evt_class,
    input  logic              evt_is_write,
    input  logic              cnt_ovf,
    output logic              fhi_irq,
    output logic              eri_irq,
    output logic              cri_irq,
    output logic              inband_err
);

    localparam int          REG_OFF = 8 + 64 * NODE_IDX;
    localparam logic [63:0] WMASK   = ctl_mask(FEAT_RPT, FEAT_UREC, FEAT_FLT, FEAT_IBR,
                                               FEAT_CEF, FEAT_DREC, FEAT_DFLT, FEAT_CRIT,
                                               HAS_CSRC);

    logic [15:2] ctl_en;
    logic        rpt_bit;
    logic        rpt_on;
    sig_set_t    sig;

    ras_ctl_reg #(
        .ADDR_W (ADDR_W),
        .REG_OFF(REG_OFF),
        .WMASK  (WMASK)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctl_en (ctl_en),
        .rpt_bit(rpt_bit)
    );

    // a node without the reporting switch always reports
    generate
        if (FEAT_RPT == FEAT_BOTH) begin : g_rpt_sw
            assign rpt_on = rpt_bit;
        end else begin : g_rpt_fixed
            assign rpt_on = 1'b1;
        end
    endgenerate

    ras_evt_gate #(
        .FEAT_UREC(FEAT_UREC),
        .FEAT_FLT (FEAT_FLT),
        .FEAT_IBR (FEAT_IBR),
        .FEAT_CEF (FEAT_CEF),
        .FEAT_DREC(FEAT_DREC),
        .FEAT_DFLT(FEAT_DFLT),
        .FEAT_CRIT(FEAT_CRIT),
        .HAS_CSRC (HAS_CSRC)
    ) u_gate (
        .ctl_en      (ctl_en),
        .evt_valid   (evt_valid),
        .evt_class   (err_class_e'(evt_class)),
        .evt_is_write(evt_is_write),
        .cnt_ovf     (cnt_ovf),
        .sig         (sig)
    );

    ras_irq_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rpt_on    (rpt_on),
        .sig       (sig),
        .fhi_irq   (fhi_irq),
        .eri_irq   (eri_irq),
        .cri_irq   (cri_irq),
        .inband_err(inband_err)
    );

endmodule

// File: rtl/ras_node_sigctl_chk.sv
module ras_node_sigctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic [1:0]  evt_class,
    input logic        cnt_ovf,
    input logic        rpt_on,
    input logic        crit_en,
    input logic [15:0] res0_view,
    input logic        fhi,
    input logic        eri,
    input logic        cri,
    input logic        inb
);

    p_res0_hole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res0_view == 16'h0000);

    p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rpt_on) |-> !(fhi || eri || cri || inb));

    p_eri_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eri |-> ($past(evt_valid) && $past(evt_class) != 2'b00));

    p_cri_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cri |-> ($past(crit_en) && $past(evt_valid) && $past(evt_class) == 2'b11));

    p_inband_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inb |-> ($past(evt_valid) && $past(evt_class[1])));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(evt_valid) && !$past(cnt_ovf)) |-> !(fhi || eri || cri || inb));

endmodule

bind ras_node_sigctl ras_node_sigctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_valid(evt_valid),
    .evt_class(evt_class),
    .cnt_ovf  (cnt_ovf),
    .rpt_on   (rpt_on),
    .crit_en  (ctl_en[13]),
    .res0_view(bus_rdata[31:16]),
    .fhi      (fhi_irq),
    .eri      (eri_irq),
    .cri      (cri_irq),
    .inb      (inband_err)
);

// File: tb/ras_node_sigctl_tb.sv
module ras_node_sigctl_tb;

    localparam int          CLK_P = 10;
    localparam logic [15:0] OFF   = 16'h0048;
    localparam logic [63:0] MASK  = 64'hFFFF_FFFF_0000_FD7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_class = 2'b00;
    logic        evt_is_write = 1'b0;
    logic        cnt_ovf = 1'b0;
    logic        fhi_irq, eri_irq, cri_irq, inband_err;

    always #(CLK_P/2) clk = ~clk;

    ras_node_sigctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
        .evt_class(evt_class), .evt_is_write(evt_is_write), .cnt_ovf(cnt_ovf),
        .fhi_irq(fhi_irq), .eri_irq(eri_irq), .cri_irq(cri_irq), .inband_err(inband_err)
    );

    typedef struct {
        logic [3:0] exp;
        int         due;
        string      tag;
    } sb_item_t;

    sb_item_t    sbq[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [63:0] mdl = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // expected {fault, recovery, critical, in-band} from the requirements
    function automatic logic [3:0] predict(logic [63:0] m, logic v, logic [1:0] c,
                                           logic w, logic o);
        logic ui, fi, ue, cfi, dui, dfi, ci, ced, ce, unc, def;
        if (!m[0]) return 4'b0000;
        ui  = w ? m[5]  : m[2];
        fi  = w ? m[6]  : m[3];
        ue  = m[4];
        cfi = m[8];
        dui = w ? m[11] : m[10];
        dfi = w ? m[15] : m[14];
        ci  = m[13];
        ced = m[12];
        ce  = ced ? (v && c == 2'b00) : o;
        def = v && c == 2'b01;
        unc = v && (c == 2'b10 || (c == 2'b11 && !ci));
        return { (ce && cfi) || (def && (dfi ^ fi)) || (unc && fi),
                 (def && dui) || (unc && ui),
                 v && c == 2'b11 && ci,
                 v && c[1] && ue };
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due < cyc) begin
            sb_item_t it;
            logic [3:0] act;
            it  = sbq.pop_front();
            act = {fhi_irq, eri_irq, cri_irq, inband_err};
            check(act === it.exp, it.tag, 64'(act), 64'(it.exp));
        end
    end

    task automatic drive(input logic v, input logic [1:0] c, input logic w,
                         input logic o, input string tag);
        sb_item_t it;
        @(negedge clk);
        evt_valid    = v;
        evt_class    = c;
        evt_is_write = w;
        cnt_ovf      = o;
        it.exp = predict(mdl, v, c, w, o);
        it.due = cyc;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // one event followed by an idle cycle that must be quiet
    task automatic evt(input logic [1:0] c, input logic w, input string tag);
        drive(1'b1, c, w, 1'b0, tag);
        drive(1'b0, 2'b00, 1'b0, 1'b0, "R12 pulse width");
    endtask

    task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        if (a == OFF) mdl = d & MASK;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_rd(OFF, 64'h0, "R1 reset word");
        check({fhi_irq, eri_irq, cri_irq, inband_err} === 4'b0, "R1 reset outputs",
              64'({fhi_irq, eri_irq, cri_irq, inband_err}), 64'h0);

        // R3 masking
        reg_wr(OFF, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(OFF, 64'hFFFF_FFFF_0000_FD7F, "R3 writable mask");
        reg_wr(OFF, 64'h1234_5678_0000_0002);
        reg_rd(OFF, 64'h1234_5678_0000_0002, "R3 own storage bits");

        // R2 address decode
        reg_wr(OFF + 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(OFF, 64'h1234_5678_0000_0002, "R2 foreign write ignored");
        reg_rd(OFF + 16'h0040, 64'h0, "R2 foreign read zero");

        // R4 reporting off: everything else enabled
        reg_wr(OFF, 64'h0000_0000_0000_FFFE);
        evt(2'b10, 1'b0, "R4 uncorrected while off");
        evt(2'b11, 1'b1, "R4 critical while off");
        evt(2'b01, 1'b0, "R4 deferred while off");

        // R5 R10 R11 read-side split, shared in-band
        reg_wr(OFF, 64'h0000_0000_0000_001D);
        evt(2'b10, 1'b0, "R11 R5 uncorrected read");
        evt(2'b10, 1'b1, "R10 R5 uncorrected write");
        reg_wr(OFF, 64'h0000_0000_0000_0061);
        evt(2'b10, 1'b1, "R5 R11 uncorrected write side");
        evt(2'b10, 1'b0, "R5 read side off");

        // R6 deferred fault XOR
        reg_wr(OFF, 64'h0000_0000_0000_4009);
        evt(2'b01, 1'b0, "R6 both set read");
        reg_wr(OFF, 64'h0000_0000_0000_0009);
        evt(2'b01, 1'b0, "R6 fault only read");
        reg_wr(OFF, 64'h0000_0000_0000_4001);
        evt(2'b01, 1'b0, "R6 deferred only read");
        evt(2'b01, 1'b1, "R6 write side clear");
        reg_wr(OFF, 64'h0000_0000_0000_8041);
        evt(2'b01, 1'b1, "R6 both set write");
        reg_wr(OFF, 64'h0000_0000_0000_8011);
        evt(2'b01, 1'b1, "R6 R10 deferred write no inband");

        // R7 recovery for deferred
        reg_wr(OFF, 64'h0000_0000_0000_0401);
        evt(2'b01, 1'b0, "R7 deferred read");
        evt(2'b01, 1'b1, "R7 deferred write off");
        reg_wr(OFF, 64'h0000_0000_0000_0801);
        evt(2'b01, 1'b1, "R7 deferred write");

        // R8 critical
        reg_wr(OFF, 64'h0000_0000_0000_2015);
        evt(2'b11, 1'b0, "R8 critical enabled");
        reg_wr(OFF, 64'h0000_0000_0000_000D);
        evt(2'b11, 1'b0, "R8 critical as uncorrected");

        // R9 corrected event source
        reg_wr(OFF, 64'h0000_0000_0000_1101);
        evt(2'b00, 1'b0, "R9 corrected recorded");
        drive(1'b0, 2'b00, 1'b0, 1'b1, "R9 overflow ignored");
        drive(1'b0, 2'b00, 1'b0, 1'b0, "R12 pulse width");
        reg_wr(OFF, 64'h0000_0000_0000_0101);
        evt(2'b00, 1'b1, "R9 corrected not counted");
        drive(1'b0, 2'b00, 1'b1, 1'b1, "R9 overflow event");
        drive(1'b0, 2'b00, 1'b0, 1'b0, "R12 pulse width");

        // R12 back-to-back events
        reg_wr(OFF, 64'h0000_0000_0000_001D);
        drive(1'b1, 2'b10, 1'b0, 1'b0, "R12 first of pair");
        drive(1'b1, 2'b01, 1'b0, 1'b0, "R12 second of pair");
        drive(1'b0, 2'b00, 1'b0, 1'b0, "R12 after pair");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "scoreboard drained", 64'(sbq.size()), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule